// File: doc/BRIEF.md
# Sixteen-bit single-cycle processor core

This core fetches, decodes and retires one 16-bit instruction on every clock edge. A single 16-bit word holds every instruction. The core has a 16-bit program counter that counts in words and sixteen 16-bit general registers. The word splits into a 4-bit opcode in bits [15:12] and three 4-bit fields: `d` in [11:8], `s` in [7:4] and `t` in [3:0]. Where an instruction uses an immediate or offset, `t` holds it as a 4-bit two's-complement value. The core sign-extends that value to 16 bits before use.

Instruction memory and data memory are arrays inside the core. A load port fills the instruction memory before a run. Programs build their own data with stores. The trace outputs show the current PC and the register-file and data-memory write ports. On each cycle they carry exactly the write that commits at the next rising edge, so a checker can follow execution from outside the core.

Top module: `cpu16_core`

## Requirements
- R1: While `rstN` is low, `pcOut` is 0 and neither `regWe` nor `memWe` is asserted. After release, the first instruction is fetched from word 0.
- R2: Opcodes 0 to 4 are add, subtract, AND, OR and signed set-less-than. Each computes `reg[d] = reg[s] op reg[t]`. Set-less-than writes 1 or 0.
- R3: Opcodes 5 to 8 are add, AND, OR and signed set-less-than with an immediate. Each computes `reg[d] = reg[s] op sext(t)`.
- R4: Opcode 9 loads `reg[d]` from data word `reg[s]+sext(t)`. Opcode 10 stores `reg[d]` to that address and writes no register.
- R5: Opcode 11 branches when `reg[d]==reg[s]`. Opcode 12 branches when they differ. A taken branch moves to `PC+sext(t)`; a branch not taken moves to `PC+1`. Branches write nothing.
- R6: Opcode 13 shifts `reg[s]` by exactly one bit into `reg[d]`. The kind comes from `t`: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate left. Every other kind copies the value unchanged.
- R7: Opcode 14 writes `PC+1` into R15 and replaces `PC[11:0]` with instruction bits [11:0]. `PC[15:12]` is kept.
- R8: Opcode 15 loads the PC from `reg[s]` and writes nothing.
- R9: R0 always reads as zero. A write aimed at R0 is dropped and shows no trace write.
- R10: Every instruction other than a branch, call or register jump advances the PC by 1.
- R11: In the cycle before the commit, `regWe/regWaddr/regWdata` and `memWe/memAddr/memWdata` show the write that commits at the next rising edge.
- R12: A rising edge with `loadEn` high writes `loadData` into instruction word `loadAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Instruction memory write strobe |
| loadAddr | input | 16 | Instruction word address for loading |
| loadData | input | 16 | Instruction word to load |
| pcOut | output | 16 | Address of the instruction now executing |
| regWe | output | 1 | A register write commits at the next edge |
| regWaddr | output | 4 | Register being written |
| regWdata | output | 16 | Value being written to the register |
| memWe | output | 1 | A data memory write commits at the next edge |
| memAddr | output | 16 | Data memory word address |
| memWdata | output | 16 | Value being stored |

## Verification
The case that is hardest to reach from the ports is a call followed by a return. The return address sits in R15 and shows up only in the trace, so it can be checked only by going there. The program calls a routine at a distant address and returns from it with a register jump. The PC sequence must then resume right after the call. It also runs a branch over an instruction that must not execute, an equality branch between registers produced by a load, and a backward branch. A write to R0 is aimed so that the following read proves the write was dropped.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int WORD_W = 16;
  localparam int REG_COUNT = 16;
  localparam int RIDX_W = $clog2(REG_COUNT);
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(REG_COUNT - 1);

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT,
    OP_ADDI, OP_ANDI, OP_ORI, OP_SLTI,
    OP_LW, OP_SW, OP_BEQ, OP_BNE, OP_SHIFT, OP_JAL, OP_JR
  } opcode_e;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_SHIFT, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic    regWrite;
    logic    memWrite;
    logic    useImm;
    logic    readDst;
    alu_op_e aluOp;
    wb_sel_e wbSel;
    logic    branchEq;
    logic    branchNe;
    logic    jal;
    logic    jr;
  } ctrl_t;
endpackage

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    ctrl.wbSel = WB_ALU;
    unique case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT: begin
        ctrl.regWrite = 1'b1;
        ctrl.aluOp = alu_op_e'(op[2:0]);
      end
      OP_ADDI: begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_ANDI: begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_AND; end
      OP_ORI:  begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_OR;  end
      OP_SLTI: begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_SLT; end
      OP_LW: begin
        ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.wbSel = WB_MEM;
      end
      OP_SW: begin
        ctrl.memWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.readDst = 1'b1;
      end
      OP_BEQ: begin ctrl.branchEq = 1'b1; ctrl.readDst = 1'b1; end
      OP_BNE: begin ctrl.branchNe = 1'b1; ctrl.readDst = 1'b1; end
      OP_SHIFT: begin ctrl.regWrite = 1'b1; ctrl.wbSel = WB_SHIFT; end
      OP_JAL: begin ctrl.regWrite = 1'b1; ctrl.wbSel = WB_LINK; ctrl.jal = 1'b1; end
      OP_JR: ctrl.jr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = W'($signed(a) < $signed(b));
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/cpu16_datapath.sv
module cpu16_datapath
  import cpu16_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] instr,
  output logic [WORD_W-1:0] pcOut,
  output logic              regWe,
  output logic [RIDX_W-1:0] regWaddr,
  output logic [WORD_W-1:0] regWdata,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);
  localparam int IA_W = $clog2(IMEM_DEPTH);
  localparam int DA_W = $clog2(DMEM_DEPTH);
  localparam int TGT_W = WORD_W - 4;

  logic [WORD_W-1:0] pc, pcNext, pcInc;
  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [WORD_W-1:0] dmem [DMEM_DEPTH];
  logic [WORD_W-1:0] regs [REG_COUNT];
  logic [RIDX_W-1:0] fD, fS, fT, rbAddr;
  logic [WORD_W-1:0] immExt, rdA, rdB, aluB, aluY, shiftY, memRdata;
  logic              taken;

  assign instr  = imem[pc[IA_W-1:0]];
  assign fD     = instr[11:8];
  assign fS     = instr[7:4];
  assign fT     = instr[3:0];
  assign immExt = {{(WORD_W-4){fT[3]}}, fT};
  assign rbAddr = ctrl.readDst ? fD : fT;
  assign rdA    = (fS == '0) ? '0 : regs[fS];
  assign rdB    = (rbAddr == '0) ? '0 : regs[rbAddr];
  assign aluB   = ctrl.useImm ? immExt : rdB;

  cpu16_alu #(.W(WORD_W)) uAlu (.a(rdA), .b(aluB), .op(ctrl.aluOp), .y(aluY));

  always_comb begin
    unique case (fT)
      4'd0: shiftY = {rdA[WORD_W-2:0], 1'b0};
      4'd1: shiftY = {1'b0, rdA[WORD_W-1:1]};
      4'd2: shiftY = {rdA[WORD_W-1], rdA[WORD_W-1:1]};
      4'd3: shiftY = {rdA[WORD_W-2:0], rdA[WORD_W-1]};
      default: shiftY = rdA;
    endcase
  end

  assign memRdata = dmem[aluY[DA_W-1:0]];
  assign pcInc = pc + 1'b1;
  assign taken = (ctrl.branchEq && (rdA == rdB)) || (ctrl.branchNe && (rdA != rdB));

  always_comb begin
    if (ctrl.jal)      pcNext = {pc[WORD_W-1:TGT_W], instr[TGT_W-1:0]};
    else if (ctrl.jr)  pcNext = rdA;
    else if (taken)    pcNext = pc + immExt;
    else               pcNext = pcInc;
  end

  always_comb begin
    unique case (ctrl.wbSel)
      WB_MEM:   regWdata = memRdata;
      WB_SHIFT: regWdata = shiftY;
      WB_LINK:  regWdata = pcInc;
      default:  regWdata = aluY;
    endcase
  end

  assign regWaddr = ctrl.jal ? LINK_REG : fD;
  assign regWe    = rstN && ctrl.regWrite && (regWaddr != '0);
  assign memWe    = rstN && ctrl.memWrite;
  assign memAddr  = aluY;
  assign memWdata = rdB;
  assign pcOut    = pc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (regWe) regs[regWaddr] <= regWdata;
    if (memWe) dmem[memAddr[DA_W-1:0]] <= memWdata;
    if (loadEn) imem[loadAddr[IA_W-1:0]] <= loadData;
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic [15:0] loadAddr,
  input  logic [15:0] loadData,
  output logic [15:0] pcOut,
  output logic        regWe,
  output logic [3:0]  regWaddr,
  output logic [15:0] regWdata,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [15:0] memWdata
);
  ctrl_t       ctrl;
  logic [15:0] instrWord;

  cpu16_ctrl uCtrl (.op(opcode_e'(instrWord[15:12])), .ctrl(ctrl));

  cpu16_datapath #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .instr(instrWord), .pcOut(pcOut),
    .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] instrWord,
  input logic [15:0] pcOut,
  input logic        regWe,
  input logic [3:0]  regWaddr,
  input logic [15:0] regWdata,
  input logic        memWe
);
  logic [3:0] op;
  assign op = instrWord[15:12];

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (op <= 4'd10 || op == 4'd13) |=> pcOut == $past(pcOut) + 16'd1); // R10
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd14) |-> (regWe && regWaddr == 4'd15 && regWdata == pcOut + 16'd1)); // R7
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd14) |=> pcOut == {$past(pcOut[15:12]), $past(instrWord[11:0])}); // R7
  AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> regWaddr != 4'd0); // R9
  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (op == 4'd10 && !regWe)); // R4
  AST_BRANCH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (op == 4'd11 || op == 4'd12 || op == 4'd15) |-> (!regWe && !memWe)); // R5
endmodule

bind cpu16_core cpu16_core_chk uChk (
  .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcOut(pcOut),
  .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata), .memWe(memWe)
);

// File: tb/cpu16_core_test.sv
module cpu16_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] loadAddr = '0, loadData = '0;
  logic [15:0] pcOut, regWdata, memAddr, memWdata;
  logic        regWe, memWe;
  logic [3:0]  regWaddr;

  int checks = 0, errors = 0;
  bit runStart = 0, finished = 0;

  typedef struct {
    string       tag;
    logic [15:0] pc;
    int          kind;  // 0 none, 1 register write, 2 memory write
    logic [15:0] addr;
    logic [15:0] data;
  } exp_t;
  exp_t expQ[$];

  cpu16_core uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .pcOut(pcOut), .regWe(regWe), .regWaddr(regWaddr), .regWdata(regWdata),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] enc(int op, int d, int s, int t);
    return {op[3:0], d[3:0], s[3:0], t[3:0]};
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic loadWord(int addr, logic [15:0] w);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = 16'(addr); loadData = w;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic expectStep(string tag, int pc, int kind, int addr, int data);
    exp_t e;
    e.tag = tag; e.pc = 16'(pc); e.kind = kind; e.addr = 16'(addr); e.data = 16'(data);
    expQ.push_back(e);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: one expected item per cycle, sampled away from the rising edge
  initial begin
    wait (runStart);
    while (expQ.size() > 0) begin
      exp_t e;
      #1;
      e = expQ.pop_front();
      check(e.tag, "pc", pcOut, e.pc);
      case (e.kind)
        1: begin
          check(e.tag, "regWe", 16'(regWe), 16'd1);
          check(e.tag, "regWaddr", 16'(regWaddr), e.addr);
          check(e.tag, "regWdata", regWdata, e.data);
          check(e.tag, "memWe", 16'(memWe), 16'd0);
        end
        2: begin
          check(e.tag, "memWe", 16'(memWe), 16'd1);
          check(e.tag, "memAddr", memAddr, e.addr);
          check(e.tag, "memWdata", memWdata, e.data);
          check(e.tag, "regWe", 16'(regWe), 16'd0);
        end
        default: begin
          check(e.tag, "regWe", 16'(regWe), 16'd0);
          check(e.tag, "memWe", 16'(memWe), 16'd0);
        end
      endcase
      @(negedge clk);
    end
    summary();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    // R12: program loaded through the load port while reset is held
    loadWord(0,  enc(5, 1, 0, 7));     // ADDI R1 = 7
    loadWord(1,  enc(5, 2, 0, -3));    // ADDI R2 = -3
    loadWord(2,  enc(0, 3, 1, 2));     // ADD
    loadWord(3,  enc(1, 4, 1, 2));     // SUB
    loadWord(4,  enc(2, 5, 1, 2));     // AND
    loadWord(5,  enc(3, 6, 1, 2));     // OR
    loadWord(6,  enc(4, 7, 2, 1));     // SLT true
    loadWord(7,  enc(4, 8, 1, 2));     // SLT false
    loadWord(8,  enc(6, 9, 2, 6));     // ANDI
    loadWord(9,  enc(7, 10, 1, -8));   // ORI
    loadWord(10, enc(8, 11, 2, -2));   // SLTI
    loadWord(11, enc(10, 1, 3, 2));    // SW R1 -> [R3+2]
    loadWord(12, enc(9, 12, 3, 2));    // LW R12 <- [R3+2]
    loadWord(13, enc(5, 0, 1, 5));     // ADDI R0 (dropped)
    loadWord(14, enc(0, 13, 0, 1));    // ADD R13 = R0 + R1
    loadWord(15, enc(13, 14, 2, 0));
    loadWord(16, enc(13, 14, 2, 1));
    loadWord(17, enc(13, 14, 2, 2));
    loadWord(18, enc(13, 14, 2, 3));
    loadWord(19, enc(13, 14, 2, 7));
    loadWord(20, enc(11, 1, 2, 3));    // BEQ not taken
    loadWord(21, enc(12, 1, 2, 2));    // BNE taken -> 23
    loadWord(22, enc(5, 1, 0, 1));     // must be skipped
    loadWord(23, enc(11, 13, 12, 2));  // BEQ taken -> 25
    loadWord(24, enc(5, 1, 0, 1));     // must be skipped
    loadWord(25, {4'hE, 12'h040});     // JAL 0x040
    loadWord(64, enc(5, 3, 1, 0));     // ADDI R3 = R1
    loadWord(65, enc(15, 0, 15, 0));   // JR R15
    loadWord(26, enc(12, 0, 0, 5));    // BNE not taken
    loadWord(27, enc(11, 0, 0, 3));    // BEQ taken -> 30
    loadWord(30, enc(12, 1, 0, -2));   // BNE backward -> 28
    loadWord(28, enc(5, 5, 0, 1));
    loadWord(29, enc(11, 0, 0, 0));    // halt loop

    #1;
    check("R1", "pc in reset", pcOut, 16'h0000);
    check("R1", "regWe in reset", 16'(regWe), 16'd0);
    check("R1", "memWe in reset", 16'(memWe), 16'd0);

    expectStep("R12", 0, 1, 1, 7);
    expectStep("R3", 1, 1, 2, 16'hFFFD);
    expectStep("R2", 2, 1, 3, 4);
    expectStep("R2", 3, 1, 4, 10);
    expectStep("R2", 4, 1, 5, 5);
    expectStep("R11", 5, 1, 6, 16'hFFFF);
    expectStep("R2", 6, 1, 7, 1);
    expectStep("R10", 7, 1, 8, 0);
    expectStep("R3", 8, 1, 9, 4);
    expectStep("R3", 9, 1, 10, 16'hFFFF);
    expectStep("R3", 10, 1, 11, 1);
    expectStep("R4", 11, 2, 6, 7);
    expectStep("R4", 12, 1, 12, 7);
    expectStep("R9", 13, 0, 0, 0);
    expectStep("R9", 14, 1, 13, 7);
    expectStep("R6", 15, 1, 14, 16'hFFFA);
    expectStep("R6", 16, 1, 14, 16'h7FFE);
    expectStep("R6", 17, 1, 14, 16'hFFFE);
    expectStep("R6", 18, 1, 14, 16'hFFFB);
    expectStep("R6", 19, 1, 14, 16'hFFFD);
    expectStep("R5", 20, 0, 0, 0);
    expectStep("R5", 21, 0, 0, 0);
    expectStep("R5", 23, 0, 0, 0);
    expectStep("R7", 25, 1, 15, 26);
    expectStep("R7", 64, 1, 3, 7);
    expectStep("R8", 65, 0, 0, 0);
    expectStep("R8", 26, 0, 0, 0);
    expectStep("R5", 27, 0, 0, 0);
    expectStep("R5", 30, 0, 0, 0);
    expectStep("R5", 28, 1, 5, 1);
    expectStep("R5", 29, 0, 0, 0);
    expectStep("R5", 29, 0, 0, 0);
    expectStep("R5", 29, 0, 0, 0);

    @(negedge clk);
    rstN = 1'b1;
    runStart = 1;
  end
endmodule